// File: doc/BRIEF.md
# Cascadable Dual-Byte Edge Accumulator

This block counts qualified transitions on two external pins with a pair of byte-wide accumulators. In split mode each accumulator has its own enable and its own pin: the upper byte follows the shared pin, which it shares with a capture channel elsewhere on the chip, and the lower byte follows a dedicated pin. Setting the wide-mode bit joins the two bytes into one 16-bit counter. That counter is fed only from the shared pin, and in this mode the per-byte enables are ignored.

Software reaches the block through a small register port with four addresses: control, flags, upper count and lower count. Every register can be written and read in any mode. An edge-select bit chooses rising or falling transitions for both pins. In wide mode a sticky input-edge flag records qualified transitions on the shared pin, and a sticky overflow flag records a wrap from all ones to zero. Both flags are cleared by writing 1 to their bit. Wide mode does not depend on any timer enable, so counting needs nothing outside this block.

Top module: `dual_edge_accum`

## Requirements
- R1: After reset the control bits, both count bytes and both flags read 0.
- R2: In split mode (control bit 0 = 0), the lower byte adds one per qualified edge on `pinLower` only while control bit 2 is 1, and the upper byte adds one per qualified edge on `pinShared` only while control bit 1 is 1. A disabled byte holds its value.
- R3: In wide mode (control bit 0 = 1), each qualified edge on `pinShared` adds one to the 16-bit value {upper, lower}. The lower byte carries into the upper byte when it rolls over from 0xFF to 0x00.
- R4: In wide mode, control bits 1 and 2 and the `pinLower` pin have no effect on either count.
- R5: Control bit 3 selects the qualified transition: 1 counts rising edges and 0 counts falling edges.
- R6: Flag bit 0 (input-edge flag, also on `edgeFlag`) is set by a qualified edge on `pinShared` only in wide mode. It never sets in split mode.
- R7: Flag bit 1 (overflow, also on `ovfFlag`) is set when a wide-mode edge wraps {upper, lower} from 0xFFFF to 0x0000. It is not set by any other count change.
- R8: Writing 1 to a bit of the flag register (address 1) clears that flag, and writing 0 leaves it unchanged. If a clearing write and a setting event fall in the same cycle, the flag stays set.
- R9: A write to a count byte in the same cycle as a qualified edge loads the written value, and that edge is lost for that byte.
- R10: Register map: address 0 is control (bit 0 wide mode, bit 1 upper enable, bit 2 lower enable, bit 3 rising select, upper bits read 0 and are not stored), address 1 holds the flags, address 2 the upper count and address 3 the lower count. All of them can be written and read at any time.
- R11: A pin level present at clock edge N shows in the count after clock edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, applied on the clock edge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | BYTE_W | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | BYTE_W | Read data, combinational from `rdAddr` |
| pinShared | input | 1 | Edge pin for the upper byte in split mode and for the 16-bit counter in wide mode |
| pinLower | input | 1 | Edge pin for the lower byte in split mode |
| edgeFlag | output | 1 | Input-edge flag |
| ovfFlag | output | 1 | Overflow flag |

## Verification
The hardest situations to reach from the ports are the collisions: a clearing write or a count load has to arrive in exactly the cycle in which a pin transition, delayed by the synchronizer, turns into an edge pulse. The stimulus changes the pin on a falling clock edge and waits two clock periods. It then starts the register write, so that the write and the edge pulse meet on the same rising edge. A wrap from 0xFFFF is reached by preloading both count bytes through the register port rather than by counting 65536 edges.

// File: rtl/dea_pkg.sv
package dea_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_BITS = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd3;
  localparam int PIN_SHARED = 0;
  localparam int PIN_LOWER  = 1;
  localparam int NUM_PINS   = 2;

  // Field order gives bit 0 = wide, bit 3 = rise.
  typedef struct packed {
    logic rise;
    logic loEn;
    logic hiEn;
    logic wide;
  } ctrl_t;

  typedef struct packed {
    logic loInc;
    logic hiInc;
    logic loLoad;
    logic hiLoad;
    logic edgeSet;
    logic edgeClr;
    logic ovfSet;
    logic ovfClr;
  } strobe_t;
endpackage

// File: rtl/dea_edge_sync.sv
module dea_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic riseSel,
  output logic hit
);
  logic [STAGES-1:0] chain;
  logic prevLvl;
  logic curLvl;

  assign curLvl = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain   <= '0;
      prevLvl <= 1'b0;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prevLvl <= curLvl;
    end
  end

  assign hit = riseSel ? (curLvl & ~prevLvl) : (~curLvl & prevLvl);
endmodule

// File: rtl/dea_ctrl.sv
module dea_ctrl
  import dea_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CTRL_BITS-1:0] wrBits,
  input  logic                 pinShared,
  input  logic                 pinLower,
  input  logic                 loFull,
  input  logic                 hiFull,
  output ctrl_t                ctrlQ,
  output strobe_t              st
);
  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] edgeHit;
  logic loWr;
  logic hiWr;
  logic flagWr;

  assign pinVec[PIN_SHARED] = pinShared;
  assign pinVec[PIN_LOWER]  = pinLower;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    dea_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk     (clk),
      .rstN    (rstN),
      .pin     (pinVec[g]),
      .riseSel (ctrlQ.rise),
      .hit     (edgeHit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (wrEn && wrAddr == A_CTRL) ctrlQ <= ctrl_t'(wrBits);
  end

  assign loWr   = wrEn && (wrAddr == A_LO);
  assign hiWr   = wrEn && (wrAddr == A_HI);
  assign flagWr = wrEn && (wrAddr == A_FLAG);

  always_comb begin
    st         = '0;
    st.loLoad  = loWr;
    st.hiLoad  = hiWr;
    st.edgeClr = flagWr & wrBits[0];
    st.ovfClr  = flagWr & wrBits[1];
    if (ctrlQ.wide) begin
      st.loInc   = edgeHit[PIN_SHARED] & ~loWr;
      st.hiInc   = edgeHit[PIN_SHARED] & ~loWr & loFull & ~hiWr;
      st.ovfSet  = edgeHit[PIN_SHARED] & ~loWr & loFull & hiFull & ~hiWr;
      st.edgeSet = edgeHit[PIN_SHARED];
    end else begin
      st.loInc = ctrlQ.loEn & edgeHit[PIN_LOWER] & ~loWr;
      st.hiInc = ctrlQ.hiEn & edgeHit[PIN_SHARED] & ~hiWr;
    end
  end
endmodule

// File: rtl/dea_datapath.sv
module dea_datapath
  import dea_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  ctrl_t             ctrlQ,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] loCount,
  output logic [BYTE_W-1:0] hiCount,
  output logic              loFull,
  output logic              hiFull,
  output logic              edgeFlag,
  output logic              ovfFlag
);
  always_ff @(posedge clk) begin
    if (!rstN) loCount <= '0;
    else if (st.loLoad) loCount <= wrData;
    else if (st.loInc) loCount <= loCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hiCount <= '0;
    else if (st.hiLoad) hiCount <= wrData;
    else if (st.hiInc) hiCount <= hiCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (st.edgeSet) edgeFlag <= 1'b1;
      else if (st.edgeClr) edgeFlag <= 1'b0;
      if (st.ovfSet) ovfFlag <= 1'b1;
      else if (st.ovfClr) ovfFlag <= 1'b0;
    end
  end

  assign loFull = &loCount;
  assign hiFull = &hiCount;

  always_comb begin
    unique case (rdAddr)
      A_CTRL:  rdData = BYTE_W'(ctrlQ);
      A_FLAG:  rdData = BYTE_W'({ovfFlag, edgeFlag});
      A_HI:    rdData = hiCount;
      default: rdData = loCount;
    endcase
  end
endmodule

// File: rtl/dual_edge_accum.sv
module dual_edge_accum
  import dea_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              pinShared,
  input  logic              pinLower,
  output logic              edgeFlag,
  output logic              ovfFlag
);
  ctrl_t   ctrlQ;
  strobe_t st;
  logic [BYTE_W-1:0] loCount;
  logic [BYTE_W-1:0] hiCount;
  logic loFull;
  logic hiFull;
  logic wideEn;
  logic loEnable;

  assign wideEn   = ctrlQ.wide;
  assign loEnable = ctrlQ.loEn;

  dea_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrBits    (wrData[CTRL_BITS-1:0]),
    .pinShared (pinShared),
    .pinLower  (pinLower),
    .loFull    (loFull),
    .hiFull    (hiFull),
    .ctrlQ     (ctrlQ),
    .st        (st)
  );

  dea_datapath #(.BYTE_W(BYTE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .ctrlQ    (ctrlQ),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .loCount  (loCount),
    .hiCount  (hiCount),
    .loFull   (loFull),
    .hiFull   (hiFull),
    .edgeFlag (edgeFlag),
    .ovfFlag  (ovfFlag)
  );
endmodule

// File: rtl/dual_edge_accum_chk.sv
module dual_edge_accum_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic [BYTE_W-1:0] loCount,
  input logic [BYTE_W-1:0] hiCount,
  input logic              wideEn,
  input logic              loEnable,
  input logic              edgeFlag,
  input logic              ovfFlag
);
  logic loWr;
  logic hiWr;
  logic edgeClrWr;

  assign loWr      = wrEn && (wrAddr == 2'd3);
  assign hiWr      = wrEn && (wrAddr == 2'd2);
  assign edgeClrWr = wrEn && (wrAddr == 2'd1) && wrData[0];

  // R9
  lo_load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWr |=> loCount == $past(wrData));

  // R3
  hi_carry_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wideEn && !hiWr && !(&loCount)) |=> $stable(hiCount));

  // R2
  lo_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wideEn && !loEnable && !loWr) |=> $stable(loCount));

  // R6
  edge_flag_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wideEn && !edgeFlag) |=> !edgeFlag);

  // R7
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && !((&hiCount) && (&loCount))) |=> !ovfFlag);

  // R8
  edge_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeFlag && !edgeClrWr) |=> edgeFlag);
endmodule

bind dual_edge_accum dual_edge_accum_chk #(.BYTE_W(BYTE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .loCount  (loCount),
  .hiCount  (hiCount),
  .wideEn   (wideEn),
  .loEnable (loEnable),
  .edgeFlag (edgeFlag),
  .ovfFlag  (ovfFlag)
);

// File: tb/tb_dual_edge_accum.sv
module tb_dual_edge_accum;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {addr, write data, expected read-back}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {8'd0, 8'hF6, 8'h06},
    {8'd0, 8'h00, 8'h00},
    {8'd2, 8'hA5, 8'hA5},
    {8'd3, 8'h3C, 8'h3C},
    {8'd3, 8'hFF, 8'hFF},
    {8'd2, 8'h00, 8'h00},
    {8'd1, 8'h03, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic pinShared = 1'b0;
  logic pinLower = 1'b0;
  logic edgeFlag;
  logic ovfFlag;
  int checks = 0;
  int failures = 0;

  dual_edge_accum dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinShared(pinShared), .pinLower(pinLower),
    .edgeFlag(edgeFlag), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulseShared();
    pinShared = 1'b1; repeat (4) tick();
    pinShared = 1'b0; repeat (4) tick();
  endtask

  task automatic pulseLower();
    pinLower = 1'b1; repeat (4) tick();
    pinLower = 1'b0; repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    // R1 reset state
    regRead(2'd0, v); check("R1 ctrl", v, 8'h00);
    regRead(2'd1, v); check("R1 flags", v, 8'h00);
    regRead(2'd2, v); check("R1 hi", v, 8'h00);
    regRead(2'd3, v); check("R1 lo", v, 8'h00);
    rstN = 1'b1;
    tick();

    // R10 register table
    for (int i = 0; i < NVEC; i++) begin
      regWrite(VEC[i][17:16], VEC[i][15:8]);
      regRead(VEC[i][17:16], v);
      check("R10 table", v, VEC[i][7:0]);
    end

    // R2 split mode, both enabled, rising
    regWrite(2'd2, 8'h00); regWrite(2'd3, 8'h00);
    regWrite(2'd0, 8'h0E);
    repeat (3) pulseLower();
    repeat (2) pulseShared();
    regRead(2'd3, v); check("R2 lo split", v, 8'h03);
    regRead(2'd2, v); check("R2 hi split", v, 8'h02);
    regRead(2'd1, v); check("R6 no flag in split", v, 8'h00);

    // R2 lower disabled
    regWrite(2'd0, 8'h0A);
    repeat (2) pulseLower();
    regRead(2'd3, v); check("R2 lo disabled", v, 8'h03);

    // R5 falling select
    regWrite(2'd0, 8'h06);
    pinLower = 1'b1; repeat (4) tick();
    regRead(2'd3, v); check("R5 rising ignored", v, 8'h03);
    pinLower = 1'b0; repeat (4) tick();
    regRead(2'd3, v); check("R5 falling counted", v, 8'h04);

    // R3 / R4 wide mode, individual enables off
    regWrite(2'd0, 8'h09);
    regWrite(2'd3, 8'hFE); regWrite(2'd2, 8'h12);
    repeat (3) pulseShared();
    regRead(2'd3, v); check("R3 lo carry", v, 8'h01);
    regRead(2'd2, v); check("R3 hi carry", v, 8'h13);
    repeat (2) pulseLower();
    regRead(2'd3, v); check("R4 pinLower ignored", v, 8'h01);
    regRead(2'd1, v); check("R6 R7 flags wide", v, 8'h01);
    check("R6 edgeFlag pin", {7'd0, edgeFlag}, 8'h01);

    // R8 clear by one, zero no effect
    regWrite(2'd1, 8'h00);
    regRead(2'd1, v); check("R8 zero write", v, 8'h01);
    regWrite(2'd1, 8'h01);
    regRead(2'd1, v); check("R8 clear", v, 8'h00);

    // R7 overflow wrap
    regWrite(2'd3, 8'hFF); regWrite(2'd2, 8'hFF);
    pulseShared();
    regRead(2'd3, v); check("R7 lo wrap", v, 8'h00);
    regRead(2'd2, v); check("R7 hi wrap", v, 8'h00);
    regRead(2'd1, v); check("R7 ovf set", v, 8'h03);
    check("R7 ovfFlag pin", {7'd0, ovfFlag}, 8'h01);

    // R8 clear and edge in same cycle: edge wins for edge flag, ovf clears
    pinShared = 1'b1; tick(); tick();
    regWrite(2'd1, 8'h03);
    pinShared = 1'b0; repeat (4) tick();
    regRead(2'd1, v); check("R8 edge beats clear", v, 8'h01);

    // R9 load beats edge
    regWrite(2'd3, 8'h20); regWrite(2'd2, 8'h40);
    pinShared = 1'b1; tick(); tick();
    regWrite(2'd3, 8'h50);
    pinShared = 1'b0; repeat (4) tick();
    regRead(2'd3, v); check("R9 lo load wins", v, 8'h50);
    regRead(2'd2, v); check("R9 hi untouched", v, 8'h40);

    // R11 latency
    pinShared = 1'b1;
    tick(); regRead(2'd3, v); check("R11 after N", v, 8'h50);
    tick(); regRead(2'd3, v); check("R11 after N+1", v, 8'h50);
    tick(); regRead(2'd3, v); check("R11 after N+2", v, 8'h51);
    pinShared = 1'b0; repeat (4) tick();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule